// File: doc/BRIEF.md
# T3 Far-End Block Error Bit Generator

This block supplies the value of the three far-end block error (FEBE) C bits that sit in subframe 4 of each transmitted T3 M-frame when C-bit parity framing is used. Receive-side logic raises an error flag whenever it sees a framing bit error or a C-bit parity error. The block gathers these flags over one received M-frame and reports the result in the next transmitted M-frame. A reported error is sent as 000, which is the active code. A clean frame is sent as 111, which is the null code.

A defeat control turns off automatic reporting. A force control then chooses a fixed code: 111 or 000. The block latches the code and the active state once per transmitted M-frame, at the frame-start strobe, so all three FEBE positions in one frame always carry the same value. The frame assembler marks each FEBE position with a strobe. At a strobed position the assembler replaces its own C bit with `febe_bit` when `ins_en` is high. When the line is in E3 mode, or in a T3 framing other than C-bit parity, the block stays idle and the C bits pass through unchanged.

Top module: `t3_febe_gen`

## Requirements
- R1: After reset, `ins_en` is 0 even while `febe_slot` is 1, and `febe_bit` is 1, until the first `tx_mf_start`.
- R2: If `t3_sel` or `cbit_sel` is 0 at a `tx_mf_start`, `ins_en` stays 0 at every `febe_slot` of that transmitted frame.
- R3: In automatic mode (`auto_off`=0), if `rx_err` was seen in the received frame closed by the last `rx_mf_end`, the next transmitted frame carries `febe_bit`=0 (code 000) at all three slots.
- R4: In automatic mode, if no `rx_err` was seen in that received frame, the next transmitted frame carries `febe_bit`=1 (code 111).
- R5: With `auto_off`=1 and `force_act`=0, every frame carries `febe_bit`=1, whatever the receive errors.
- R6: With `auto_off`=1 and `force_act`=1, every frame carries `febe_bit`=0, whatever the receive errors.
- R7: `febe_bit` and the active state change only at `tx_mf_start`. Changes to controls, `rx_err` or `rx_mf_end` in the middle of a frame do not alter the value at later slots of the same frame.
- R8: One `tx_mf_start` consumes a pending error report. A second transmitted frame with no new `rx_mf_end` carrying an error sends 111.
- R9: An `rx_err` seen in a received frame that has not yet been closed by `rx_mf_end` is not reported. It is reported after that `rx_mf_end`.
- R10: While the block is active, `ins_en` follows `febe_slot` in the same cycle and is 0 whenever `febe_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t3_sel | input | 1 | 1 = T3 line mode, 0 = E3 |
| cbit_sel | input | 1 | 1 = C-bit parity framing in use |
| auto_off | input | 1 | 1 = automatic reporting defeated, code set by `force_act` |
| force_act | input | 1 | When defeated: 0 = send 111, 1 = send 000 |
| rx_err | input | 1 | Receive framing bit or C-bit parity error seen this cycle |
| rx_mf_end | input | 1 | Strobe closing a received M-frame |
| tx_mf_start | input | 1 | Strobe opening a transmitted M-frame |
| febe_slot | input | 1 | Strobe marking a FEBE C-bit position |
| febe_bit | output | 1 | Value to insert at the FEBE positions |
| ins_en | output | 1 | 1 = replace the C bit with `febe_bit` at this position |

## Verification
The main function runs through a set of frame patterns. Each pattern combines a line mode, framing, defeat setting, force setting, and a preceding received frame that is either clean or errored. Errored and clean frames in automatic mode show that errors drive the code. Forced modes paired with the opposite error state show that the override wins over the receive side. E3 and non-C-bit settings with an error pending show that insertion is suppressed. Directed sequences then separate three cases: an error still open in the current received frame, an error already reported, and control changes made in the middle of a frame.

// File: rtl/t3_febe_gen.sv
module t3_febe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic t3_sel,
  input  logic cbit_sel,
  input  logic auto_off,
  input  logic force_act,
  input  logic rx_err,
  input  logic rx_mf_end,
  input  logic tx_mf_start,
  input  logic febe_slot,
  output logic febe_bit,
  output logic ins_en
);

  logic err_acc, err_pend, act_q, code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_acc  <= 1'b0;
      err_pend <= 1'b0;
      act_q    <= 1'b0;
      code_q   <= 1'b1;
    end else begin
      if (rx_mf_end)   err_acc <= 1'b0;
      else if (rx_err) err_acc <= 1'b1;

      if (rx_mf_end)        err_pend <= err_acc | rx_err;
      else if (tx_mf_start) err_pend <= 1'b0;

      if (tx_mf_start) begin
        act_q  <= t3_sel & cbit_sel;
        code_q <= auto_off ? ~force_act : ~err_pend;
      end
    end
  end

  assign febe_bit = code_q;
  assign ins_en   = act_q & febe_slot;

endmodule

module t3_febe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic t3_sel,
  input logic cbit_sel,
  input logic auto_off,
  input logic force_act,
  input logic tx_mf_start,
  input logic febe_slot,
  input logic febe_bit,
  input logic ins_en
);

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mf_start |=> $stable(febe_bit));

  // R10
  ins_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> febe_slot);

  // R2
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mf_start && !(t3_sel && cbit_sel)) |=> !ins_en);

  // R5
  forced_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mf_start && auto_off && !force_act) |=> febe_bit);

  // R6
  forced_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mf_start && auto_off && force_act) |=> !febe_bit);

endmodule

bind t3_febe_gen t3_febe_gen_chk u_chk (.*);

// File: tb/sim_t3_febe_gen.sv
module sim_t3_febe_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t3_sel = 1'b1, cbit_sel = 1'b1, auto_off = 1'b0, force_act = 1'b0;
  logic rx_err = 1'b0, rx_mf_end = 1'b0, tx_mf_start = 1'b0, febe_slot = 1'b0;
  logic febe_bit, ins_en;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  t3_febe_gen u0 (.*);

  // {t3, cbit, auto_off, force_act, err, exp_en, exp_bit}
  localparam logic [6:0] VEC [8] = '{
    7'b1100_1_10,  // R3
    7'b1100_0_11,  // R4
    7'b1110_1_11,  // R5
    7'b1111_0_10,  // R6
    7'b0100_1_00,  // R2 E3
    7'b1000_1_00,  // R2 no C-bit
    7'b1111_1_10,  // R6
    7'b1110_0_11   // R5
  };
  localparam int VREQ [8] = '{3, 4, 5, 6, 2, 2, 6, 5};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic close_rx(input logic err);
    rx_err = err; step(); rx_err = 1'b0;
    rx_mf_end = 1'b1; step(); rx_mf_end = 1'b0;
  endtask

  task automatic open_tx();
    tx_mf_start = 1'b1; step(); tx_mf_start = 1'b0; step();
  endtask

  task automatic slot_chk(input string req, input logic een, input logic ebit, input bit cbit_v);
    febe_slot = 1'b1; #2;
    chk(req, ins_en, een);
    if (cbit_v) chk(req, febe_bit, ebit);
    step(); febe_slot = 1'b0; step();
  endtask

  initial begin
    repeat (3) step();
    febe_slot = 1'b1; #2;
    chk("R1", ins_en, 1'b0);
    chk("R1", febe_bit, 1'b1);
    febe_slot = 1'b0;
    rst_n = 1'b1; step();

    for (int i = 0; i < 8; i++) begin
      close_rx(VEC[i][2]);
      {t3_sel, cbit_sel, auto_off, force_act} = VEC[i][6:3];
      open_tx();
      for (int s = 0; s < 3; s++)
        slot_chk($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][1], VEC[i][0], VEC[i][1]);
    end

    {t3_sel, cbit_sel, auto_off, force_act} = 4'b1100;
    // R8: one report per error
    close_rx(1'b1);
    open_tx();
    slot_chk("R8 first", 1'b1, 1'b0, 1'b1);
    open_tx();
    slot_chk("R8 second", 1'b1, 1'b1, 1'b1);

    // R9: open receive frame not reported yet
    rx_err = 1'b1; step(); rx_err = 1'b0; step();
    open_tx();
    slot_chk("R9 open", 1'b1, 1'b1, 1'b1);
    rx_mf_end = 1'b1; step(); rx_mf_end = 1'b0;
    open_tx();
    slot_chk("R9 closed", 1'b1, 1'b0, 1'b1);

    // R10: no insert without slot
    #2 chk("R10", ins_en, 1'b0);
    step();

    // R7: mid-frame changes ignored
    {auto_off, force_act} = 2'b11;
    open_tx();
    slot_chk("R7 base", 1'b1, 1'b0, 1'b1);
    {auto_off, force_act} = 2'b00;
    t3_sel = 1'b0;
    close_rx(1'b0);
    slot_chk("R7 after change", 1'b1, 1'b0, 1'b1);
    slot_chk("R7 third", 1'b1, 1'b0, 1'b1);
    open_tx();
    slot_chk("R7 next frame", 1'b0, 1'b1, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule